// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address by reading a three-level radix translation table from memory. A request arrives after the translation cache misses, together with the root table's physical page number from the supervisor translation register. The walker then issues up to three dependent 64-bit reads. Each read uses one 9-bit index slice of the virtual address and the page number found at the level above it. The walk ends with a physical address or a page fault.

A walk can stop early when an upper-level entry is a leaf. At level 1 that leaf maps a 2 MiB region, and at level 2 it maps a 1 GiB region. For those leaves the low index fields of the virtual address take the place of the matching low page-number fields. The walker handles one request at a time. Its read port is a simple one: the request is a single-cycle strobe that memory accepts at once, and exactly one response beat returns later. The walker never has more than one read outstanding.

Entry layout used throughout:
- Bit 0 is the valid flag.
- Bits 3:1 are the read, write and execute permissions, in that order.
- Bits 53:10 hold the 44-bit page number. Its low field is in bits 18:10, its middle field in bits 27:19 and its high field in bits 53:28.

Virtual address layout:
- Bits 38:30 are the level-2 index.
- Bits 29:21 are the level-1 index.
- Bits 20:12 are the level-0 index.
- Bits 11:0 are the page offset.

Top module: `ptw_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the walker shows `req_ready`=1, `resp_valid`=0 and `mem_req`=0.
- R2: The first read of a walk goes to root_ppn*4096 + vaddr[38:30]*8, using the root page number captured when the request was accepted.
- R3: Every later read goes to P*4096 + idx*8. Here P is entry bits 53:10 of the previous entry, and idx is vaddr[29:21] for the second read and vaddr[20:12] for the third. A non-leaf entry is one with bit 0 = 1 and bits 3:1 = 000.
- R4: A leaf at level 0 produces paddr = {entry[53:10], vaddr[11:0]} after three reads.
- R5: A leaf at level 1 produces a paddr in which bits 20:12 come from vaddr[20:12] and bits 55:21 from entry[53:19], after two reads.
- R6: A leaf at level 2 produces a paddr in which bits 29:12 come from vaddr[29:12] and bits 55:30 from entry[53:28], after one read.
- R7: An entry with bit 0 = 0 ends the walk with `resp_fault`=1 and issues no further reads.
- R8: An entry with bit 0 = 1, bit 2 (write) = 1 and bit 1 (read) = 0 ends the walk with `resp_fault`=1.
- R9: A non-leaf entry at level 0 ends the walk with `resp_fault`=1 after three reads.
- R10: From the accepting handshake until the response is taken, `req_ready` stays 0. While `resp_valid`=1 and `resp_ready`=0, `resp_paddr` and `resp_fault` hold steady.
- R11: No more than one read is outstanding at any time, and a walk issues no more than three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request after a translation-cache miss |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 39 | Virtual address to translate |
| root_ppn | input | 44 | Root table page number from the translation register |
| mem_req | output | 1 | Single-cycle read strobe, accepted at once |
| mem_addr | output | 56 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| resp_valid | output | 1 | Translation result available |
| resp_ready | input | 1 | Consumer takes the result |
| resp_paddr | output | 56 | Physical address (zero on a fault) |
| resp_fault | output | 1 | Page fault indication |

## Verification
The walker is driven with randomly built table paths. At each level the bench picks one of four entry kinds: a pointer, a leaf with legal permissions, an invalid entry or a write-without-read entry. Together these cover every way a walk can end at every depth. Directed walks add three cases:
- clean 4 KiB, 2 MiB and 1 GiB mappings whose leaf page numbers carry nonzero low fields, which separates correct field substitution from plain concatenation;
- all-zero and all-one virtual addresses, which expose slice misplacement;
- a fault at each level.

The read-address log tells a wrong index slice apart from a stale table page number, and random response back-pressure tests that the result is held.

// File: rtl/ptw_pkg.sv
// Package: shared encodings for the page table walker.
// Assumes entries are 8 bytes and carry flags in their low bits.
package ptw_pkg;

    // Walk sequencer states
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_RESP  = 2'd3
    } walk_state_e;

    // Classification of one fetched entry
    typedef struct packed {
        logic valid;
        logic leaf;
        logic fault;
    } pte_class_t;

    localparam int ENT_LG    = 3;   // log2 of entry size in bytes
    localparam int BIT_V     = 0;
    localparam int BIT_R     = 1;
    localparam int BIT_W     = 2;
    localparam int BIT_X     = 3;
    localparam int PPN_LSB   = 10;

endpackage

// File: rtl/ptw_index.sv
// Module: ptw_index
// Picks the index slice of the virtual address for the current level and
// forms the byte address of the entry inside the current table page.
// Assumes VA_W = OFF_W + LEVELS*IDX_W and a table fills exactly one page.
module ptw_index
    import ptw_pkg::*;
#(
    parameter int VA_W   = 39,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int PPN_W  = 44,
    parameter int PA_W   = PPN_W + OFF_W,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    input  logic [PPN_W-1:0] table_ppn,
    output logic [PA_W-1:0]  entry_addr
);

    localparam int HI_PAD = PA_W - IDX_W - ENT_LG;

    logic [IDX_W-1:0] slice [LEVELS];
    logic [IDX_W-1:0] sel_idx;

    // One index slice per level, laid out above the page offset
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
    end

    // Select the slice for the level being walked
    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) sel_idx = slice[i];
        end
    end

    // Table base plus scaled index
    always_comb begin
        entry_addr = {table_ppn, {OFF_W{1'b0}}}
                   | {{HI_PAD{1'b0}}, sel_idx, {ENT_LG{1'b0}}};
    end

endmodule

// File: rtl/ptw_pte_decode.sv
// Module: ptw_pte_decode
// Classifies a fetched entry as pointer, leaf or fault and extracts its
// page number. Assumes R/W/X flags sit directly above the valid bit.
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int PPN_W = 44
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             last_level,
    output pte_class_t       cls,
    output logic [PPN_W-1:0] ppn
);

    logic f_v, f_r, f_w, f_x;

    // Split out the flag bits
    always_comb begin
        f_v = pte[BIT_V];
        f_r = pte[BIT_R];
        f_w = pte[BIT_W];
        f_x = pte[BIT_X];
    end

    // Leaf and fault rules
    always_comb begin
        cls.valid = f_v;
        cls.leaf  = f_r | f_w | f_x;
        cls.fault = !f_v
                  || (f_w && !f_r)
                  || (!(f_r | f_w | f_x) && last_level);
    end

    // Page number field
    always_comb begin
        ppn = pte[PPN_LSB +: PPN_W];
    end

endmodule

// File: rtl/ptw_paddr_compose.sv
// Module: ptw_paddr_compose
// Builds the final physical address from a leaf page number. For a leaf
// above level 0 the low index fields of the virtual address replace the
// matching low page-number fields. Assumes the top field is the widest.
module ptw_paddr_compose #(
    parameter int VA_W   = 39,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int PPN_W  = 44,
    parameter int PA_W   = PPN_W + OFF_W,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] leaf_level,
    input  logic [PPN_W-1:0] leaf_ppn,
    output logic [PA_W-1:0]  paddr
);

    localparam int LOW_W = (LEVELS-1) * IDX_W;

    logic [PPN_W-1:0] mixed;

    // Top page-number field always comes from the entry
    assign mixed[PPN_W-1:LOW_W] = leaf_ppn[PPN_W-1:LOW_W];

    // Lower fields: virtual index below the leaf level, entry field otherwise
    for (genvar g = 0; g < LEVELS-1; g++) begin : g_field
        assign mixed[g*IDX_W +: IDX_W] = (LVL_W'(g) < leaf_level)
                                       ? vaddr[OFF_W + g*IDX_W +: IDX_W]
                                       : leaf_ppn[g*IDX_W +: IDX_W];
    end

    // Append the untouched page offset
    assign paddr = {mixed, vaddr[OFF_W-1:0]};

endmodule

// File: rtl/ptw_top.sv
// Module: ptw_top
// Sequences a multi-level table walk: accepts one request, reads one
// entry per level, stops on leaf or fault, then holds the result until
// taken. Assumes memory accepts mem_req at once and returns exactly one
// mem_rvalid beat per request.
module ptw_top
    import ptw_pkg::*;
#(
    parameter int VA_W   = 39,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int PPN_W  = 44,
    parameter int PTE_W  = 64,
    parameter int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PPN_W-1:0] root_ppn,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             resp_valid,
    input  logic             resp_ready,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault
);

    localparam int LVL_W = $clog2(LEVELS);

    walk_state_e      state_q;
    logic [VA_W-1:0]  va_q;
    logic [PPN_W-1:0] tbl_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PA_W-1:0]  pa_q;
    logic             fault_q;

    logic [PA_W-1:0]  entry_addr;
    pte_class_t       cls;
    logic [PPN_W-1:0] pte_ppn;
    logic [PA_W-1:0]  leaf_pa;
    logic             at_last;

    assign at_last = (lvl_q == '0);

    ptw_index #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
        .PPN_W(PPN_W), .PA_W(PA_W), .LVL_W(LVL_W)
    ) u_index (
        .vaddr      (va_q),
        .level      (lvl_q),
        .table_ppn  (tbl_q),
        .entry_addr (entry_addr)
    );

    ptw_pte_decode #(
        .PTE_W(PTE_W), .PPN_W(PPN_W)
    ) u_decode (
        .pte        (mem_rdata),
        .last_level (at_last),
        .cls        (cls),
        .ppn        (pte_ppn)
    );

    ptw_paddr_compose #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
        .PPN_W(PPN_W), .PA_W(PA_W), .LVL_W(LVL_W)
    ) u_compose (
        .vaddr      (va_q),
        .leaf_level (lvl_q),
        .leaf_ppn   (pte_ppn),
        .paddr      (leaf_pa)
    );

    // Walk sequencer: capture, issue, consume entry, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            va_q    <= '0;
            tbl_q   <= '0;
            lvl_q   <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                W_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        tbl_q   <= root_ppn;
                        lvl_q   <= LVL_W'(LEVELS-1);
                        state_q <= W_ISSUE;
                    end
                end
                W_ISSUE: begin
                    state_q <= W_WAIT;
                end
                W_WAIT: begin
                    if (mem_rvalid) begin
                        if (cls.fault) begin
                            fault_q <= 1'b1;
                            pa_q    <= '0;
                            state_q <= W_RESP;
                        end else if (cls.leaf) begin
                            fault_q <= 1'b0;
                            pa_q    <= leaf_pa;
                            state_q <= W_RESP;
                        end else begin
                            tbl_q   <= pte_ppn;
                            lvl_q   <= lvl_q - 1'b1;
                            state_q <= W_ISSUE;
                        end
                    end
                end
                W_RESP: begin
                    if (resp_ready) state_q <= W_IDLE;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state
    always_comb begin
        req_ready  = (state_q == W_IDLE);
        mem_req    = (state_q == W_ISSUE);
        mem_addr   = entry_addr;
        resp_valid = (state_q == W_RESP);
        resp_paddr = pa_q;
        resp_fault = fault_q;
    end

endmodule

// File: rtl/ptw_checker.sv
// Module: ptw_checker
// Protocol and sequencing properties of ptw_top, bound to every instance.
// Assumes the port semantics given in the brief.
module ptw_checker #(
    parameter int VA_W   = 39,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int PPN_W  = 44,
    parameter int PTE_W  = 64,
    parameter int PA_W   = PPN_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [PPN_W-1:0] root_ppn,
    input logic             mem_req,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_rvalid,
    input logic [PTE_W-1:0] mem_rdata,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic [PA_W-1:0]  resp_paddr,
    input logic             resp_fault
);

    logic       outst_q;
    logic [3:0] reads_q;

    // Track one outstanding read and reads per walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
            reads_q <= '0;
        end else begin
            if (mem_req)         outst_q <= 1'b1;
            else if (mem_rvalid) outst_q <= 1'b0;
            if (req_valid && req_ready) reads_q <= '0;
            else if (mem_req)           reads_q <= reads_q + 1'b1;
        end
    end

    // R1: reset leaves the walker idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !resp_valid && !mem_req));

    // R2: first read indexes the captured root table with the top slice
    a_r2_root_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (mem_req
             && mem_addr[PA_W-1:OFF_W] == $past(root_ppn)
             && mem_addr[OFF_W-1:0] ==
                OFF_W'({$past(req_vaddr[VA_W-1 -: IDX_W]), 3'b000})));

    // R10: busy after accept
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: result held under back-pressure
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=>
            (resp_valid && $stable(resp_paddr) && $stable(resp_fault)));

    // R11: at most one outstanding read
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outst_q);

    // R11: bounded number of reads per walk
    a_r11_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (reads_q < 4'(LEVELS)));

    // R10: no read while a result waits
    a_r10_quiet_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (!mem_req && !req_ready));

endmodule

bind ptw_top ptw_checker #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .PPN_W(PPN_W), .PTE_W(PTE_W), .PA_W(PA_W)
) u_ptw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .root_ppn   (root_ppn),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_paddr (resp_paddr),
    .resp_fault (resp_fault)
);

// File: tb/tb_ptw_top.sv
// Bench for ptw_top: sparse behavioural memory, random and directed walks,
// expected results from a bench-side walk function.
module tb_ptw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [38:0] req_vaddr = '0;
    logic [43:0] root_ppn = '0;
    logic        mem_req;
    logic [55:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [55:0] resp_paddr;
    logic        resp_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    ptw_top dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_ppn(root_ppn),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    // Sparse memory and read log
    logic [63:0] pmem [logic [55:0]];
    logic [55:0] rd_log [$];
    logic        m_busy = 1'b0;
    logic [1:0]  m_lat = '0;
    logic [55:0] m_addr = '0;

    function automatic logic [63:0] mrd(input logic [55:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    // Memory: accepts a strobe, answers two cycles later
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (!rst_n) begin
            m_busy <= 1'b0;
        end else if (mem_req) begin
            m_busy <= 1'b1;
            m_lat  <= 2'd1;
            m_addr <= mem_addr;
            rd_log.push_back(mem_addr);
        end else if (m_busy) begin
            if (m_lat == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mrd(m_addr);
                m_busy     <= 1'b0;
            end else begin
                m_lat <= m_lat - 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected walk outcome
    logic [55:0] e_pa;
    bit          e_flt;
    int          e_nrd;
    int          e_lvl;
    string       e_tag;
    logic [55:0] e_ad [3];

    task automatic ref_walk(input logic [38:0] va, input logic [43:0] root);
        logic [43:0] tbl = root;
        logic [63:0] pte;
        logic [43:0] pp;
        e_nrd = 0; e_flt = 0; e_pa = '0; e_tag = "R4";
        for (int lvl = 2; lvl >= 0; lvl--) begin
            e_ad[e_nrd] = {tbl, 12'h0} + 56'(va[12 + 9*lvl +: 9]) * 8;
            pte = mrd(e_ad[e_nrd]);
            e_nrd++;
            e_lvl = lvl;
            if (!pte[0]) begin e_flt = 1; e_tag = "R7"; return; end
            if (pte[2] && !pte[1]) begin e_flt = 1; e_tag = "R8"; return; end
            if (pte[3:1] != 0) begin
                pp = pte[53:10];
                if (lvl >= 1) pp[8:0]  = va[20:12];
                if (lvl == 2) pp[17:9] = va[29:21];
                e_pa = {pp, va[11:0]};
                e_tag = (lvl == 0) ? "R4" : (lvl == 1) ? "R5" : "R6";
                return;
            end
            if (lvl == 0) begin e_flt = 1; e_tag = "R9"; return; end
            tbl = pte[53:10];
        end
    endtask

    function automatic logic [43:0] rnd_ppn();
        return {12'($urandom), $urandom};
    endfunction

    // Kinds: 0 pointer, 1 leaf, 2 invalid, 3 write-only
    task automatic build(input logic [38:0] va, input logic [43:0] root,
                         input int k2, input int k1, input int k0,
                         input logic [43:0] lppn);
        logic [43:0] tbl = root;
        logic [55:0] a;
        logic [43:0] nx;
        logic [2:0]  perm;
        int ks [3];
        ks[2] = k2; ks[1] = k1; ks[0] = k0;
        pmem.delete();
        for (int lvl = 2; lvl >= 0; lvl--) begin
            a = {tbl, 12'h0} + 56'(va[12 + 9*lvl +: 9]) * 8;
            case (ks[lvl])
                0: begin
                    nx = rnd_ppn();
                    pmem[a] = {10'h0, nx, 6'h0, 4'b0001};
                    tbl = nx;
                end
                1: begin
                    case ($urandom % 5)
                        0: perm = 3'b001;
                        1: perm = 3'b011;
                        2: perm = 3'b100;
                        3: perm = 3'b101;
                        default: perm = 3'b111;
                    endcase
                    pmem[a] = {10'h0, lppn, 6'h0, perm, 1'b1};
                    return;
                end
                2: begin
                    pmem[a] = {$urandom, $urandom} & ~64'h1;
                    return;
                end
                default: begin
                    pmem[a] = {10'h0, lppn, 6'h0, 1'($urandom), 2'b10, 1'b1};
                    return;
                end
            endcase
        end
    endtask

    task automatic walk(input logic [38:0] va, input logic [43:0] root,
                        input int hold);
        int t = 0;
        bit early_ready = 0;
        logic [55:0] pa0;
        logic        f0;
        ref_walk(va, root);
        rd_log.delete();
        @(negedge clk);
        req_vaddr = va; root_ppn = root; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 39'($urandom);
        root_ppn  = rnd_ppn();
        chk(req_ready == 1'b0, "R10", "ready after accept", 64'(req_ready), 64'h0);
        while (!resp_valid && t < 400) begin
            if (req_ready) early_ready = 1;
            @(negedge clk);
            t++;
        end
        chk(t < 400, e_tag, "watchdog", 64'(t), 64'd400);
        if (t >= 400) return;
        chk(!early_ready, "R10", "ready during walk", 64'(early_ready), 64'h0);
        chk(resp_fault == e_flt, e_tag, "fault flag", 64'(resp_fault), 64'(e_flt));
        if (!e_flt)
            chk(resp_paddr == e_pa, e_tag, "paddr", 64'(resp_paddr), 64'(e_pa));
        chk(rd_log.size() == e_nrd, "R11", "read count",
            64'(rd_log.size()), 64'(e_nrd));
        for (int i = 0; i < e_nrd && i < rd_log.size(); i++)
            chk(rd_log[i] == e_ad[i], (i == 0) ? "R2" : "R3", "read address",
                64'(rd_log[i]), 64'(e_ad[i]));
        pa0 = resp_paddr; f0 = resp_fault;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(resp_valid && resp_paddr == pa0 && resp_fault == f0, "R10",
                "held result", {7'h0, resp_valid, resp_paddr}, {8'h1, pa0});
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk(!resp_valid && req_ready, "R10", "release",
            {62'h0, resp_valid, req_ready}, 64'h1);
    endtask

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req, "R1", "in reset",
            {61'h0, req_ready, resp_valid, mem_req}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req, "R1", "after reset",
            {61'h0, req_ready, resp_valid, mem_req}, 64'h4);

        // Directed: 4 KiB, 2 MiB, 1 GiB mappings with nonzero low fields
        build(39'h12_3456_789A, 44'h10, 0, 0, 1, 44'hABC_DEF0_1FF);
        walk(39'h12_3456_789A, 44'h10, 0);
        build(39'h55_5555_5555, 44'h777, 0, 1, 0, 44'h123_4567_89AB);
        walk(39'h55_5555_5555, 44'h777, 3);
        build(39'h2A_AAAA_AAAA, 44'hFFF_FFFF_FFFF, 1, 0, 0, 44'h3FF_FFFF_FFFF);
        walk(39'h2A_AAAA_AAAA, 44'hFFF_FFFF_FFFF, 1);
        build(39'h0, 44'h1, 0, 0, 1, 44'h987_6543_210F);
        walk(39'h0, 44'h1, 0);
        build(39'h7F_FFFF_FFFF, 44'h2, 0, 0, 1, 44'h0);
        walk(39'h7F_FFFF_FFFF, 44'h2, 2);
        // Directed faults at each level
        build(39'h01_0203_0405, 44'h40, 2, 0, 0, 44'h5);
        walk(39'h01_0203_0405, 44'h40, 0);
        build(39'h01_0203_0405, 44'h40, 0, 3, 0, 44'h5);
        walk(39'h01_0203_0405, 44'h40, 0);
        build(39'h01_0203_0405, 44'h40, 0, 0, 0, 44'h5);
        walk(39'h01_0203_0405, 44'h40, 0);
        build(39'h3C_0000_0FFF, 44'h41, 0, 0, 2, 44'h5);
        walk(39'h3C_0000_0FFF, 44'h41, 0);

        // Random walks
        for (int n = 0; n < 400; n++) begin
            logic [38:0] va = {7'($urandom), $urandom};
            logic [43:0] rt = rnd_ppn();
            int kk [3];
            for (int l = 0; l < 3; l++) begin
                int r = $urandom % 10;
                kk[l] = (r < 5) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3;
            end
            build(va, rt, kk[2], kk[1], kk[0], rnd_ppn());
            walk(va, rt, $urandom % 4);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule